// File: doc/BRIEF.md
# Cycle Counter Compare Timer

The block keeps a free-running counter that wraps modulo 2^CNT_W and one to three compare registers. On every clock the counter moves forward, by one on a plain tick or by an arbitrary step when a bulk-advance command models time that passed while the core was halted. Each comparator owns a sticky interrupt line. The line is raised when the compare value lies inside the span the counter just covered. The test is a wrap-safe modular difference, so a value jumped over by a large step is still caught.

For wake-up scheduling the block continuously reports how many cycles remain until the nearest compare value, and the counter value at that point. A skip command jumps the counter to one past that wake point in a single clock and applies the same match rule over the skipped span. Software loads the counter and each compare value through plain write ports. Routing the interrupt lines to interrupt numbers is done outside the block.

Top module: `cycle_timer`

## Requirements
- R1: While rst_ni is low the counter, every compare register and every interrupt output read zero.
- R2: With no command asserted the counter rises by exactly one per clock and wraps from all ones to zero.
- R3: With bulk_i high the counter rises by bulk_step_i (which may be zero) in that single clock.
- R4: On an edge where the counter moves from old value c by step d (d is 1 on a tick), comparator k sets irq_o[k] when (cmp_k - c) mod 2^CNT_W <= d. The line then stays high until compare k is written.
- R5: cmp_we_i[k] loads cmp_wdata_i into compare k and clears irq_o[k]. If a match on the old compare value lands on the same edge, the write wins and the line ends low.
- R6: cnt_we_i loads cnt_wdata_i into the counter, and no comparator is evaluated on that edge.
- R7: wake_dist_o equals the smallest (cmp_k - cnt) mod 2^CNT_W over all comparators, capped at all ones. wake_pt_o equals cnt_o + wake_dist_o.
- R8: skip_i sets the counter to wake_pt_o + 1 and evaluates the match rule with d = wake_dist_o + 1.
- R9: Command priority is counter write, then skip, then bulk advance, then plain tick.
- R10: With TIMER_EN = 0 every interrupt output stays low and wake_dist_o stays all ones. Counter and compare registers still load and count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_we_i | input | 1 | Load the counter |
| cnt_wdata_i | input | CNT_W | Counter load value |
| cmp_we_i | input | NUM_CMP | Per-comparator compare write strobe |
| cmp_wdata_i | input | CNT_W | Compare write value, shared by all strobes |
| skip_i | input | 1 | Jump to one past the wake point |
| bulk_i | input | 1 | Advance by bulk_step_i instead of one |
| bulk_step_i | input | CNT_W | Bulk advance step |
| cnt_o | output | CNT_W | Current counter |
| cmp_o | output | NUM_CMP*CNT_W | Compare registers, comparator k at bits k*CNT_W upward |
| irq_o | output | NUM_CMP | Sticky timer interrupt per comparator |
| wake_dist_o | output | CNT_W | Cycles until the nearest compare value |
| wake_pt_o | output | CNT_W | Counter value at the nearest compare value |

## Verification
A compare write and a match on the same comparator can fall on one edge: the old compare value is hit by the advance while software replaces it. The bench provokes this in two ways. A directed sequence places a compare value one tick ahead and writes that comparator on exactly the matching edge. Random traffic also writes compare values close to the counter while ticks, bulk steps and skips run. A bench model applies write-wins and requires the line to read low afterwards. Counter writes colliding with skip and bulk commands are judged the same way, against the priority order.

// File: rtl/cycle_timer_pkg.sv
package cycle_timer_pkg;
  typedef enum logic [1:0] {
    CMD_TICK = 2'd0,
    CMD_BULK = 2'd1,
    CMD_SKIP = 2'd2,
    CMD_LOAD = 2'd3
  } cnt_cmd_e;
endpackage

// File: rtl/ct_counter.sv
module ct_counter
  import cycle_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             skip_i,
  input  logic [CNT_W-1:0] skip_val_i,
  input  logic             bulk_i,
  input  logic [CNT_W-1:0] bulk_step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] step_o,
  output logic             chk_o
);
  cnt_cmd_e         cmd;
  logic [CNT_W-1:0] cnt_q;

  // load > skip > bulk > tick
  always_comb begin
    if (load_i)      cmd = CMD_LOAD;
    else if (skip_i) cmd = CMD_SKIP;
    else if (bulk_i) cmd = CMD_BULK;
    else             cmd = CMD_TICK;
  end

  always_comb begin
    unique case (cmd)
      CMD_BULK: step_o = bulk_step_i;
      CMD_SKIP: step_o = skip_val_i - cnt_q;
      CMD_LOAD: step_o = '0;
      default:  step_o = CNT_W'(1);
    endcase
  end

  assign chk_o = (cmd != CMD_LOAD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (cmd == CMD_LOAD) cnt_q <= load_val_i;
    else                      cnt_q <= cnt_q + step_o;
  end

  assign cnt_o = cnt_q;

  a_r2_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !skip_i && !bulk_i) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  a_r3_bulk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !skip_i && bulk_i) |=> cnt_q == $past(cnt_q) + $past(bulk_step_i));

  a_r6_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));

  a_r9_skip_over_bulk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && skip_i) |=> cnt_q == $past(skip_val_i));
endmodule

// File: rtl/ct_comparator.sv
module ct_comparator #(
  parameter int CNT_W    = 32,
  parameter bit TIMER_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] step_i,
  input  logic             chk_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic             irq_o,
  output logic [CNT_W-1:0] dist_o
);
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] gap;
  logic             hit;
  logic             irq_q;

  // modular distance ahead of the pre-edge counter
  assign gap = cmp_q - cnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cmp_q <= '0;
    else if (we_i) cmp_q <= wdata_i;
  end

  generate
    if (TIMER_EN) begin : g_on
      assign hit    = chk_i && (gap <= step_i);
      assign dist_o = gap;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   irq_q <= 1'b0;
        else if (we_i) irq_q <= 1'b0;
        else if (hit)  irq_q <= 1'b1;
      end

      a_r4_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_q && !we_i) |=> irq_q);

      a_r4_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!we_i && chk_i && gap <= step_i) |=> irq_q);

      a_r6_no_eval: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!chk_i && !irq_q) |=> !irq_q);
    end else begin : g_off
      assign hit    = 1'b0;
      assign dist_o = '1;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) irq_q <= 1'b0;
        else         irq_q <= 1'b0;
      end

      a_r10_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_q && (chk_i || !chk_i) && step_i == step_i);
    end
  endgenerate

  assign cmp_o = cmp_q;
  assign irq_o = irq_q;

  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> !irq_q && cmp_q == $past(wdata_i));
endmodule

// File: rtl/ct_wake_min.sv
module ct_wake_min #(
  parameter int CNT_W   = 32,
  parameter int NUM_CMP = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_CMP*CNT_W-1:0] dist_i,
  output logic [CNT_W-1:0]         dist_o
);
  logic [CNT_W-1:0] best;

  // all ones when nothing is closer: a full wrap away
  always_comb begin
    best = '1;
    for (int i = 0; i < NUM_CMP; i++) begin
      if (dist_i[i*CNT_W +: CNT_W] < best) best = dist_i[i*CNT_W +: CNT_W];
    end
  end

  assign dist_o = best;

  always_ff @(posedge clk_i) begin
    if (rst_ni) begin
      for (int i = 0; i < NUM_CMP; i++) begin
        a_r7_min: assert (dist_o <= dist_i[i*CNT_W +: CNT_W]);
      end
    end
  end
endmodule

// File: rtl/cycle_timer.sv
module cycle_timer #(
  parameter int CNT_W    = 32,
  parameter int NUM_CMP  = 3,
  parameter bit TIMER_EN = 1'b1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cnt_we_i,
  input  logic [CNT_W-1:0]         cnt_wdata_i,
  input  logic [NUM_CMP-1:0]       cmp_we_i,
  input  logic [CNT_W-1:0]         cmp_wdata_i,
  input  logic                     skip_i,
  input  logic                     bulk_i,
  input  logic [CNT_W-1:0]         bulk_step_i,
  output logic [CNT_W-1:0]         cnt_o,
  output logic [NUM_CMP*CNT_W-1:0] cmp_o,
  output logic [NUM_CMP-1:0]       irq_o,
  output logic [CNT_W-1:0]         wake_dist_o,
  output logic [CNT_W-1:0]         wake_pt_o
);
  localparam int DIST_W = NUM_CMP * CNT_W;

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  step;
  logic              chk;
  logic [CNT_W-1:0]  skip_val;
  logic [DIST_W-1:0] dist_all;

  assign skip_val = wake_pt_o + CNT_W'(1);

  ct_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (cnt_we_i),
    .load_val_i  (cnt_wdata_i),
    .skip_i      (skip_i),
    .skip_val_i  (skip_val),
    .bulk_i      (bulk_i),
    .bulk_step_i (bulk_step_i),
    .cnt_o       (cnt),
    .step_o      (step),
    .chk_o       (chk)
  );

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    ct_comparator #(.CNT_W(CNT_W), .TIMER_EN(TIMER_EN)) i_cmp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cnt_i   (cnt),
      .step_i  (step),
      .chk_i   (chk),
      .we_i    (cmp_we_i[g]),
      .wdata_i (cmp_wdata_i),
      .cmp_o   (cmp_o[g*CNT_W +: CNT_W]),
      .irq_o   (irq_o[g]),
      .dist_o  (dist_all[g*CNT_W +: CNT_W])
    );
  end

  ct_wake_min #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) i_wake (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dist_i (dist_all),
    .dist_o (wake_dist_o)
  );

  assign cnt_o     = cnt;
  assign wake_pt_o = cnt + wake_dist_o;

  initial begin
    a_cfg_num_cmp: assert (NUM_CMP >= 1 && NUM_CMP <= 3);
  end

  a_r8_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (skip_i && !cnt_we_i) |=> cnt_o == $past(wake_pt_o) + CNT_W'(1));

  a_r9_load_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_we_i && (skip_i || bulk_i)) |=> cnt_o == $past(cnt_wdata_i));
endmodule

// File: tb/test_cycle_timer.sv
module test_cycle_timer;
  localparam int CLK_P   = 10;
  localparam int W       = 32;
  localparam int NUM_CMP = 3;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               cnt_we = 1'b0;
  logic [W-1:0]       cnt_wdata = '0;
  logic [NUM_CMP-1:0] cmp_we = '0;
  logic [W-1:0]       cmp_wdata = '0;
  logic               skip = 1'b0;
  logic               bulk = 1'b0;
  logic [W-1:0]       bulk_step = '0;

  logic [W-1:0]         cnt_o, dist_o, pt_o, cnt_off, dist_off, pt_off;
  logic [NUM_CMP*W-1:0] cmp_o, cmp_off;
  logic [NUM_CMP-1:0]   irq_o, irq_off;

  int n_tests = 0;
  int n_fail  = 0;

  logic [W-1:0] m_cnt;
  logic [W-1:0] m_cmp [NUM_CMP];
  logic         m_irq [NUM_CMP];

  always #(CLK_P/2) clk = ~clk;

  cycle_timer #(.CNT_W(W), .NUM_CMP(NUM_CMP), .TIMER_EN(1'b1)) i_cycle_timer (
    .clk_i(clk), .rst_ni(rst_n), .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wdata),
    .cmp_we_i(cmp_we), .cmp_wdata_i(cmp_wdata), .skip_i(skip), .bulk_i(bulk),
    .bulk_step_i(bulk_step), .cnt_o(cnt_o), .cmp_o(cmp_o), .irq_o(irq_o),
    .wake_dist_o(dist_o), .wake_pt_o(pt_o));

  cycle_timer #(.CNT_W(W), .NUM_CMP(NUM_CMP), .TIMER_EN(1'b0)) i_cycle_timer_off (
    .clk_i(clk), .rst_ni(rst_n), .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wdata),
    .cmp_we_i(cmp_we), .cmp_wdata_i(cmp_wdata), .skip_i(skip), .bulk_i(bulk),
    .bulk_step_i(bulk_step), .cnt_o(cnt_off), .cmp_o(cmp_off), .irq_o(irq_off),
    .wake_dist_o(dist_off), .wake_pt_o(pt_off));

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] min_dist();
    logic [W-1:0] best = '1;
    for (int i = 0; i < NUM_CMP; i++)
      if (m_cmp[i] - m_cnt < best) best = m_cmp[i] - m_cnt;
    return best;
  endfunction

  // one clock: predict, wait for the edge, compare, release the inputs
  task automatic run_cycle();
    logic [W-1:0] e_cnt, d, mind;
    logic         ev;
    string        tag;
    mind = min_dist();
    ev   = 1'b1;
    if (cnt_we) begin
      e_cnt = cnt_wdata; d = '0; ev = 1'b0;
      tag = (skip || bulk) ? "R9" : "R6";
    end else if (skip) begin
      d = mind + 1; e_cnt = m_cnt + d; tag = bulk ? "R9" : "R8";
    end else if (bulk) begin
      d = bulk_step; e_cnt = m_cnt + d; tag = "R3";
    end else begin
      d = 1; e_cnt = m_cnt + 1; tag = "R2";
    end
    for (int i = 0; i < NUM_CMP; i++) begin
      if (cmp_we[i]) begin
        m_irq[i] = 1'b0; m_cmp[i] = cmp_wdata;
      end else if (ev && (m_cmp[i] - m_cnt <= d)) begin
        m_irq[i] = 1'b1;
      end
    end
    m_cnt = e_cnt;
    @(posedge clk);
    #(CLK_P/4);
    chk({tag, " counter"}, cnt_o, m_cnt);
    for (int i = 0; i < NUM_CMP; i++) begin
      chk("R5 compare value", cmp_o[i*W +: W], m_cmp[i]);
      chk("R4 R5 irq", {31'd0, irq_o[i]}, {31'd0, m_irq[i]});
    end
    chk("R7 wake distance", dist_o, min_dist());
    chk("R7 wake point", pt_o, m_cnt + min_dist());
    chk("R10 irq off", {29'd0, irq_off}, '0);
    chk("R10 dist off", dist_off, '1);
    cnt_we = 1'b0; cmp_we = '0; skip = 1'b0; bulk = 1'b0;
  endtask

  task automatic wr_cmp(input int k, input logic [W-1:0] v);
    cmp_we[k] = 1'b1; cmp_wdata = v; run_cycle();
  endtask

  initial begin
    #(CLK_P * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] tgt;
    void'($urandom(32'd1234));
    m_cnt = '0;
    for (int i = 0; i < NUM_CMP; i++) begin m_cmp[i] = '0; m_irq[i] = 1'b0; end
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    chk("R1 reset counter", cnt_o, '0);
    chk("R1 reset compares", cmp_o[W-1:0] | cmp_o[2*W-1:W] | cmp_o[3*W-1:2*W], '0);
    chk("R1 reset irq", {29'd0, irq_o}, '0);
    rst_n = 1'b1;

    // first edge out of reset hits compare value 0
    run_cycle();
    wr_cmp(0, 32'd100); wr_cmp(1, 32'd200); wr_cmp(2, 32'd300);
    repeat (5) run_cycle();

    // R2 wrap, R6 load
    cnt_we = 1'b1; cnt_wdata = 32'hFFFF_FFFE; run_cycle();
    chk("R6 load value", cnt_o, 32'hFFFF_FFFE);
    wr_cmp(0, 32'd2);
    repeat (4) run_cycle();
    chk("R2 wrapped count", cnt_o, 32'd3);
    chk("R4 hit across wrap", {31'd0, irq_o[0]}, 32'd1);

    // R3/R4 bulk: boundary of d
    wr_cmp(1, m_cnt + 80);
    bulk = 1'b1; bulk_step = 32'd78; run_cycle();
    chk("R4 one short no hit", {31'd0, irq_o[1]}, 32'd0);
    bulk = 1'b1; bulk_step = 32'd0; run_cycle();
    chk("R3 zero step holds", cnt_o, m_cnt);
    run_cycle();
    chk("R4 tick reaches compare", {31'd0, irq_o[1]}, 32'd1);
    wr_cmp(1, m_cnt + 50);
    bulk = 1'b1; bulk_step = 32'd1000; run_cycle();
    chk("R4 jumped over compare", {31'd0, irq_o[1]}, 32'd1);

    // R5 write lands on the matching edge
    wr_cmp(2, m_cnt + 3);
    run_cycle();
    cmp_we[2] = 1'b1; cmp_wdata = m_cnt + 32'd5000; run_cycle();
    chk("R5 write beats match", {31'd0, irq_o[2]}, 32'd0);

    // R8 skip to nearest
    wr_cmp(0, m_cnt + 500); wr_cmp(1, m_cnt + 300); wr_cmp(2, m_cnt + 900);
    tgt = m_cmp[1];
    skip = 1'b1; run_cycle();
    chk("R8 skip lands past wake", cnt_o, tgt + 1);
    chk("R8 skip fires nearest", {29'd0, irq_o}, 32'd2);

    // R9 all commands together
    cnt_we = 1'b1; cnt_wdata = 32'h1234_5678; skip = 1'b1; bulk = 1'b1; bulk_step = 32'd7;
    run_cycle();
    chk("R9 load wins", cnt_o, 32'h1234_5678);
    skip = 1'b1; bulk = 1'b1; bulk_step = 32'd3; run_cycle();

    // random mix
    for (int n = 0; n < 6000; n++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 3) begin
        cnt_we = 1'b1;
        cnt_wdata = ($urandom % 4 == 0) ? $urandom : m_cnt + ($urandom % 200);
      end
      if ($urandom % 100 < 12) begin
        cmp_we = NUM_CMP'($urandom);
        cmp_wdata = m_cnt + ($urandom % 96);
      end
      r = int'($urandom % 100);
      if (r < 20) begin
        bulk = 1'b1;
        bulk_step = ($urandom % 10 == 0) ? $urandom : ($urandom % 48);
      end else if (r < 24) begin
        skip = 1'b1;
      end
      run_cycle();
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule